// File: doc/BRIEF.md
# Gated Stream Ingress Cache

This block takes in a stream of data words from a streaming source and holds them in an internal cache until a control master reports that a memory buffer has been set aside for them. The source always starts the traffic. The block only sees it arrive, and it asks for a descriptor as soon as the first beat of a new transaction shows up. Words are accepted into the cache whether or not a buffer exists yet. Flow control pushes back on the source only when the cache has no free slot.

After a descriptor returns a base address and the control master pulses the release input, the cached words go out in arrival order on a valid/ready memory-write port. Each word's address is a fixed step past the one before it. When the word that closed the transaction has been written, the block drops its release flag. It then re-arms and waits for the next transaction, which needs its own descriptor and its own release pulse.

Top module: `stream_ingress_cache`

## Requirements
- R1: A synchronous active-high `rst` empties the cache, clears the release flag and re-arms the descriptor logic. After reset `s_tready` is 1, `wr_valid` is 0 and `desc_req` is 0. Words cached before the reset are never written out.
- R2: A beat enters the cache only on a rising clock edge where `s_tvalid` and `s_tready` are both 1. Up to DEPTH words (default 1024 words of 32 bits) are accepted while the release flag is clear.
- R3: `s_tready` is 0 exactly when the cache holds DEPTH words. While it is 0, no beat is taken, even if `s_tvalid` stays high.
- R4: While armed, the block raises `desc_req` one cycle after it sees `s_tvalid` high or finds words already in the cache. `desc_req` stays high until `desc_ack` is sampled high.
- R5: The value on `desc_addr` at the edge where both `desc_req` and `desc_ack` are high becomes `wr_addr` for the first word written. Each later word of the same transaction has an address DATA_W/8 (4) higher.
- R6: `wr_valid` stays 0 unless the release flag is set and a descriptor has been accepted. A one-cycle high on `dst_ready_set` sets the flag.
- R7: Written words leave in arrival order. `wr_data` equals the accepted `s_tdata`. `wr_last` equals the `s_tlast` that arrived with that word.
- R8: When a full cache gives up a word to the write port, `s_tready` returns to 1.
- R9: A write handshake with `wr_last` = 1 clears the release flag and re-arms the block. The next transaction waits for a fresh descriptor and a fresh `dst_ready_set` pulse. If a set pulse arrives in the same cycle as that last write, the flag stays set.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, the block holds `wr_valid`, `wr_data` and `wr_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | DATA_W | Stream data word |
| s_tvalid | input | 1 | Stream word offered |
| s_tready | output | 1 | Cache has a free slot |
| s_tlast | input | 1 | Word closes the transaction |
| dst_ready_set | input | 1 | Pulse: destination buffer allocated |
| desc_req | output | 1 | Descriptor wanted |
| desc_ack | input | 1 | Descriptor delivered |
| desc_addr | input | ADDR_W | Base write address from descriptor |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Memory side takes the word |
| wr_addr | output | ADDR_W | Byte address of the word |
| wr_data | output | DATA_W | Word to write |
| wr_last | output | 1 | Word closes the transaction |

## Verification
The checker assumes that `desc_ack` is high only while `desc_req` is high. It also assumes that `dst_ready_set` is pulsed once per transaction, after the previous transaction's closing word has been written, so that its shadow release flag and occupancy count stay in step with the port traffic. The bench follows both rules. It acknowledges a request only after the request has been high for two cycles, and it starts each transaction, with its single set pulse, only after the previous closing word has been written. `wr_ready` and `s_tvalid` are otherwise free, and the bench varies the stalls on the write side to exercise the hold rule.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [1:0] {
    REL_ARMED = 2'd0,
    REL_FETCH = 2'd1,
    REL_OPEN  = 2'd2
  } rel_state_e;
endpackage

// File: rtl/sic_fifo.sv
module sic_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             has_room,
  output logic             nonempty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    total_q, total_nx, mem_cnt_q, mem_cnt_nx;
  logic             load;

  // the output register is refilled when empty or when its word leaves
  assign load = (!out_valid || pop) && (mem_cnt_q != '0);

  always_comb begin
    total_nx = total_q;
    if (push) total_nx = total_nx + CW'(1);
    if (pop)  total_nx = total_nx - CW'(1);
    mem_cnt_nx = mem_cnt_q;
    if (push) mem_cnt_nx = mem_cnt_nx + CW'(1);
    if (load) mem_cnt_nx = mem_cnt_nx - CW'(1);
  end

  // storage array without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      total_q   <= '0;
      mem_cnt_q <= '0;
      out_valid <= 1'b0;
      has_room  <= 1'b1;
    end else begin
      if (push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      if (load) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
      total_q   <= total_nx;
      mem_cnt_q <= mem_cnt_nx;
      if (load)     out_valid <= 1'b1;
      else if (pop) out_valid <= 1'b0;
      has_room  <= (total_nx != CW'(DEPTH));
    end
  end

  assign nonempty = (total_q != '0);
endmodule

// File: rtl/sic_release_ctrl.sv
module sic_release_ctrl
  import sic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stream_seen,
  input  logic              dst_set,
  output logic              desc_req,
  input  logic              desc_ack,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              wr_fire,
  input  logic              wr_fire_last,
  output logic              drain_en,
  output logic [ADDR_W-1:0] wr_addr
);
  rel_state_e state_q;
  logic       flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= REL_ARMED;
      flag_q  <= 1'b0;
      wr_addr <= '0;
    end else begin
      case (state_q)
        REL_ARMED: if (stream_seen) state_q <= REL_FETCH;
        REL_FETCH: if (desc_ack) begin
          state_q <= REL_OPEN;
          wr_addr <= desc_addr;
        end
        REL_OPEN: if (wr_fire) begin
          wr_addr <= wr_addr + STEP;
          if (wr_fire_last) state_q <= REL_ARMED;
        end
        default: state_q <= REL_ARMED;
      endcase
      // a fresh set pulse wins over the clear from a closing write
      if (dst_set)                     flag_q <= 1'b1;
      else if (wr_fire && wr_fire_last) flag_q <= 1'b0;
    end
  end

  assign desc_req = (state_q == REL_FETCH);
  assign drain_en = (state_q == REL_OPEN) && flag_q;
endmodule

// File: rtl/stream_ingress_cache.sv
module stream_ingress_cache #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 1024,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  input  logic              dst_ready_set,
  output logic              desc_req,
  input  logic              desc_ack,
  input  logic [ADDR_W-1:0] desc_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_last
);
  logic              push, pop, out_valid, has_room, nonempty, drain_en;
  logic [WORD_W-1:0] out_word;

  assign push = s_tvalid && has_room;
  assign pop  = wr_valid && wr_ready;

  sic_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_cache (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data ({s_tlast, s_tdata}),
    .pop       (pop),
    .out_valid (out_valid),
    .out_data  (out_word),
    .has_room  (has_room),
    .nonempty  (nonempty)
  );

  sic_release_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .stream_seen  (s_tvalid || nonempty),
    .dst_set      (dst_ready_set),
    .desc_req     (desc_req),
    .desc_ack     (desc_ack),
    .desc_addr    (desc_addr),
    .wr_fire      (pop),
    .wr_fire_last (out_word[DATA_W]),
    .drain_en     (drain_en),
    .wr_addr      (wr_addr)
  );

  assign s_tready = has_room;
  assign wr_valid = out_valid && drain_en;
  assign wr_data  = out_word[DATA_W-1:0];
  assign wr_last  = out_word[DATA_W];
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              dst_ready_set,
  input logic              desc_req,
  input logic              desc_ack,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_last
);
  logic [31:0] occ_q;
  logic        flag_sh_q;
  logic        rst_d_q = 1'b0;
  logic        acc, fire;

  assign acc  = s_tvalid && s_tready;
  assign fire = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    rst_d_q <= rst;
    if (rst) begin
      occ_q     <= '0;
      flag_sh_q <= 1'b0;
    end else begin
      occ_q <= occ_q + (acc ? 32'd1 : 32'd0) - (fire ? 32'd1 : 32'd0);
      if (dst_ready_set)        flag_sh_q <= 1'b1;
      else if (fire && wr_last) flag_sh_q <= 1'b0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst_d_q && !rst |-> s_tready && !wr_valid && !desc_req);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    occ_q <= 32'(DEPTH));

  assert_ready_tracks_room_R3: assert property (@(posedge clk) disable iff (rst)
    s_tready == (occ_q != 32'(DEPTH)));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    desc_req && !desc_ack |=> desc_req);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    fire && !wr_last |=> wr_addr == $past(wr_addr) + ADDR_W'(DATA_W / 8));

  assert_gated_by_flag_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> flag_sh_q);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));
endmodule

bind stream_ingress_cache sic_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_sic_checker (
  .clk           (clk),
  .rst           (rst),
  .s_tvalid      (s_tvalid),
  .s_tready      (s_tready),
  .dst_ready_set (dst_ready_set),
  .desc_req      (desc_req),
  .desc_ack      (desc_ack),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .wr_last       (wr_last)
);

// File: tb/test_stream_ingress_cache.sv
module test_stream_ingress_cache;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int CACHE_DEPTH = 1024;
  localparam int NVEC = 5;
  // vector table: length, base address, set-pulse cycle, write stall period
  localparam int          TV_LEN  [NVEC] = '{4, 8, 12, 1, 6};
  localparam logic [31:0] TV_BASE [NVEC] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h5000};
  localparam int          TV_SET  [NVEC] = '{0, 15, 3, 2, 9};
  localparam int          TV_STALL[NVEC] = '{0, 0, 3, 0, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, dst_ready_set = 1'b0;
  logic desc_ack = 1'b0, wr_ready = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic s_tready, desc_req, wr_valid, wr_last;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [DW:0] exp_q [$];
  logic [AW-1:0] exp_addr;
  int acc_cnt, acc_at_set, low_cycles, early_writes, bad_data, bad_addr;
  bit ready_back, req_seen, done_last;

  always #4 clk = ~clk;

  stream_ingress_cache #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(CACHE_DEPTH)) i_stream_ingress_cache (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .dst_ready_set(dst_ready_set), .desc_req(desc_req),
    .desc_ack(desc_ack), .desc_addr(desc_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] pattern(input logic [31:0] base, input int idx);
    return {base[15:0], 16'(idx)};
  endfunction

  task automatic idle_inputs();
    s_tvalid = 1'b0; s_tlast = 1'b0; dst_ready_set = 1'b0;
    desc_ack = 1'b0; wr_ready = 1'b0;
  endtask

  // one transaction, driven and observed cycle by cycle from a falling edge
  task automatic run_txn(input int len, input logic [31:0] base, input int set_at, input int stall);
    int cyc = 0;
    int req_age = 0;
    bit hold_pend = 1'b0;
    logic [DW-1:0] hd;
    logic [AW-1:0] ha;
    acc_cnt = 0; acc_at_set = -1; low_cycles = 0; early_writes = 0;
    bad_data = 0; bad_addr = 0; ready_back = 0; req_seen = 0; done_last = 0;
    desc_addr = base;
    while (!done_last && cyc < len + set_at + 4000) begin
      s_tvalid = (acc_cnt < len);
      s_tdata  = pattern(base, acc_cnt);
      s_tlast  = (acc_cnt == len - 1);
      dst_ready_set = (cyc == set_at);
      if (cyc == set_at) acc_at_set = acc_cnt;
      wr_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      desc_ack = desc_req && (req_age >= 2);
      #2;
      if (hold_pend) begin
        // R10: stalled word stays put
        check(wr_valid && wr_data == hd && wr_addr == ha, "R10", "stalled word held",
              {wr_data, wr_addr}, {hd, ha});
        hold_pend = 1'b0;
      end
      if (desc_req) begin
        req_seen = 1'b1;
        if (desc_ack) begin exp_addr = base; req_age = 0; end
        else req_age++;
      end
      if (!s_tready) low_cycles++;
      else if (low_cycles > 0 && cyc > set_at) ready_back = 1'b1;
      if (s_tvalid && s_tready) begin
        exp_q.push_back({s_tlast, s_tdata});
        acc_cnt++;
      end
      if (wr_valid) begin
        if (cyc <= set_at) early_writes++;
        if (wr_ready) begin
          if (exp_q.size() == 0) bad_data++;
          else begin
            logic [DW:0] e = exp_q.pop_front();
            if ({wr_last, wr_data} != e) begin
              bad_data++;
              $display("FAIL R7 write word actual=%0h expected=%0h", {wr_last, wr_data}, e);
            end
          end
          if (wr_addr != exp_addr) begin
            bad_addr++;
            $display("FAIL R5 write address actual=%0h expected=%0h", wr_addr, exp_addr);
          end
          exp_addr = exp_addr + 32'd4;
          if (wr_last) done_last = 1'b1;
        end else begin
          hold_pend = 1'b1; hd = wr_data; ha = wr_addr;
        end
      end
      @(negedge clk);
      cyc++;
    end
    idle_inputs();
    check(done_last, "R9", "closing word written", 64'(done_last), 64'd1);
    check(bad_data == 0 && exp_q.size() == 0, "R7", "order and content of words",
          64'(bad_data + exp_q.size()), 64'd0);
    check(bad_addr == 0, "R5", "address sequence from base", 64'(bad_addr), 64'd0);
    check(early_writes == 0, "R6", "no write before release pulse", 64'(early_writes), 64'd0);
    check(req_seen, "R4", "descriptor requested", 64'(req_seen), 64'd1);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "WATCHDOG", "run did not end", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check(s_tready == 1'b1 && wr_valid == 1'b0 && desc_req == 1'b0, "R1", "state after reset",
          {61'd0, s_tready, wr_valid, desc_req}, 64'h4);
    @(negedge clk);

    // table-driven transactions
    for (int v = 0; v < NVEC; v++) begin
      run_txn(TV_LEN[v], TV_BASE[v], TV_SET[v], TV_STALL[v]);
      repeat (2) @(negedge clk);
      #2;
      // R9: released and re-armed, nothing pending
      check(!desc_req && !wr_valid, "R9", "idle after closing write",
            {62'd0, desc_req, wr_valid}, 64'd0);
      @(negedge clk);
    end

    // fill the whole cache before release
    run_txn(CACHE_DEPTH + 4, 32'h8000, CACHE_DEPTH + 12, 0);
    check(acc_at_set == CACHE_DEPTH, "R2", "beats held before release", 64'(acc_at_set),
          64'(CACHE_DEPTH));
    check(low_cycles >= 10, "R3", "ready low while cache full", 64'(low_cycles), 64'd10);
    check(ready_back, "R8", "ready returns after drain", 64'(ready_back), 64'd1);
    repeat (2) @(negedge clk);

    // reset in the middle of a transaction drops cached words
    s_tvalid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      s_tdata = pattern(32'h9000, i); s_tlast = 1'b0;
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    #2;
    check(s_tready && !wr_valid && !desc_req, "R1", "state after mid-run reset",
          {61'd0, s_tready, wr_valid, desc_req}, 64'h4);
    @(negedge clk);
    dst_ready_set = 1'b1; wr_ready = 1'b1;
    @(negedge clk);
    dst_ready_set = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        #2;
        if (wr_valid || desc_req) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R1", "cached words dropped by reset", 64'(seen), 64'd0);
    end
    idle_inputs();
    finish_run();
  end
endmodule